// File: doc/BRIEF.md
# Stripmined Vector Sum Reduction Engine

This block adds up a stream of N integer elements. A bank of LANES partial-sum accumulators is cleared when a run starts. The elements then arrive in chunks of up to LANES values on a wide bus, and each element is added into the accumulator of its own lane. The first chunk carries the N mod LANES leftover elements, and every later chunk carries a full LANES elements. This lets a length of any size run through the fixed-width bank.

After the last chunk is taken, the engine folds the bank by halving it. Each cycle, the upper half of the active lanes is added into the lower half. When one lane remains it holds the total, and a one-cycle valid pulse presents it. All arithmetic wraps modulo 2^ELEM_W.

A host starts a run with `start` and the element count. It then offers chunks whenever `chunk_ready` is high, sizing each chunk from `chunk_take`. The total appears on `sum_out` together with the `sum_valid` pulse.

Top module: `strip_sum_reducer`

## Requirements
- R1: After reset, `busy`, `chunk_ready` and `sum_valid` are 0 and `sum_out` is 0.
- R2: A `start` while idle latches `n_elems` and clears every lane to zero before any chunk is taken. A `start` while busy is ignored and does not change the run in progress or its result.
- R3: While `chunk_ready` is high, `chunk_take` gives the size of the chunk now expected. For the first chunk this is n_elems mod LANES, or LANES when that remainder is 0. Every later chunk has size LANES.
- R4: On a cycle with `chunk_valid` and `chunk_ready` both high, element j sits in bits [j*ELEM_W +: ELEM_W] of `chunk_data` and is added into lane j for every j < `chunk_take`. Lanes at or above `chunk_take` are not changed, whatever data they carry.
- R5: Once the last chunk is taken, the fold runs one step per cycle with half = LANES/2, LANES/4, ..., 1. In each step lane j gains lane j+half for every j < half.
- R6: `sum_valid` is a single-cycle pulse. It rises log2(LANES) clock edges after the edge that took the last chunk. `sum_out` then holds the total and keeps it until the next accepted `start`.
- R7: With n_elems = 0, no chunk is requested, and `sum_valid` rises log2(LANES) edges after the start edge with `sum_out` = 0.
- R8: The total is the sum of all N elements modulo 2^ELEM_W.
- R9: `chunk_valid` has no effect while `chunk_ready` is low, whether the engine is idle or folding.
- R10: Holding `chunk_valid` low while `chunk_ready` is high stalls the run without losing or changing any partial sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| n_elems | input | LEN_W | Number of elements in the run |
| chunk_valid | input | 1 | Chunk on chunk_data is offered |
| chunk_data | input | LANES*ELEM_W | Chunk elements, lane j in slice j |
| busy | output | 1 | Run in progress (accumulate or fold) |
| chunk_ready | output | 1 | Engine takes a chunk this cycle if offered |
| chunk_take | output | log2(LANES)+1 | Elements expected in the current chunk |
| sum_valid | output | 1 | One-cycle pulse marking the final total |
| sum_out | output | ELEM_W | Final total (lane 0) |

## Verification
Chunks are taken on the edge where `chunk_valid` and `chunk_ready` are both high. The total is due exactly six edges later for the default 64 lanes, and for a zero-length run it is due six edges after the start edge. The bench drives and samples on falling edges. From the falling edge after the last accept, it confirms that `sum_valid` stays low for six samples and is high on the sixth falling edge after that. On the next sample it checks that `sum_valid` has dropped while `sum_out` still holds the total. `chunk_take` is checked each time `chunk_ready` is seen high, before the chunk is offered.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_FOLD  = 2'd2
  } ssr_state_t;

  // Size of the next chunk given the elements still to come:
  // the leftover part goes first, full chunks afterwards.
  function automatic int unsigned chunk_len(input int unsigned left,
                                            input int unsigned lanes);
    int unsigned r;
    r = left % lanes;
    return (r == 0) ? lanes : r;
  endfunction

  // Partner lane for a fold step; half is a power of two above j.
  function automatic int unsigned fold_partner(input int unsigned j,
                                               input int unsigned half);
    return j | half;
  endfunction

endpackage

// File: rtl/ssr_strip_ctrl.sv
module ssr_strip_ctrl
  import ssr_pkg::*;
#(
  parameter int LANES = 64,
  parameter int LEN_W = 16,
  localparam int TAKE_W = $clog2(LANES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  n_elems,
  input  logic              chunk_valid,
  output logic              busy,
  output logic              chunk_ready,
  output logic [TAKE_W-1:0] take,
  output logic              clr,
  output logic              accept,
  output logic              last_chunk,
  output logic              fold_step,
  output logic [TAKE_W-1:0] fold_half,
  output logic              fold_last,
  output logic              done
);

  ssr_state_t        state;
  logic [LEN_W-1:0]  left;
  logic [TAKE_W-1:0] half;

  assign take        = TAKE_W'(chunk_len(32'(left), LANES));
  assign chunk_ready = (state == ST_ACCUM);
  assign busy        = (state != ST_IDLE);
  assign clr         = (state == ST_IDLE) && start;
  assign accept      = chunk_ready && chunk_valid;
  assign last_chunk  = accept && (left == LEN_W'(take));
  assign fold_step   = (state == ST_FOLD);
  assign fold_half   = half;
  assign fold_last   = fold_step && (half == TAKE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      left  <= '0;
      half  <= '0;
      done  <= 1'b0;
    end else begin
      done <= fold_last;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            left  <= n_elems;
            half  <= TAKE_W'(LANES / 2);
            state <= (n_elems == '0) ? ST_FOLD : ST_ACCUM;
          end
        end
        ST_ACCUM: begin
          if (accept) begin
            left <= left - LEN_W'(take);
            if (last_chunk) state <= ST_FOLD;
          end
        end
        ST_FOLD: begin
          half <= half >> 1;
          if (fold_last) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ssr_lane_bank.sv
module ssr_lane_bank
  import ssr_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int ELEM_W = 32,
  localparam int LW     = $clog2(LANES),
  localparam int TAKE_W = LW + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    add_en,
  input  logic [TAKE_W-1:0]       add_cnt,
  input  logic [LANES*ELEM_W-1:0] add_data,
  input  logic                    fold_en,
  input  logic [TAKE_W-1:0]       fold_half,
  output logic [ELEM_W-1:0]       lane0
);

  logic [ELEM_W-1:0] acc [LANES];

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [ELEM_W-1:0] q;
    logic [ELEM_W-1:0] in_j;
    logic              use_in;

    assign in_j   = add_data[j*ELEM_W +: ELEM_W];
    assign use_in = add_en && (TAKE_W'(j) < add_cnt);
    assign acc[j] = q;

    if (j < LANES / 2) begin : g_fold
      logic [ELEM_W-1:0] partner;
      logic              use_fold;
      assign partner  = acc[LW'(fold_partner(j, 32'(fold_half[LW-1:0])))];
      assign use_fold = fold_en && (TAKE_W'(j) < fold_half);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (clr)      q <= '0;
        else if (use_in)   q <= q + in_j;
        else if (use_fold) q <= q + partner;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      q <= '0;
        else if (clr)    q <= '0;
        else if (use_in) q <= q + in_j;
      end
    end
  end

  assign lane0 = acc[0];

endmodule

// File: rtl/strip_sum_reducer.sv
module strip_sum_reducer
  import ssr_pkg::*;
#(
  parameter int LANES  = 64,
  parameter int ELEM_W = 32,
  parameter int LEN_W  = 16,
  localparam int TAKE_W = $clog2(LANES) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [LEN_W-1:0]        n_elems,
  input  logic                    chunk_valid,
  input  logic [LANES*ELEM_W-1:0] chunk_data,
  output logic                    busy,
  output logic                    chunk_ready,
  output logic [TAKE_W-1:0]       chunk_take,
  output logic                    sum_valid,
  output logic [ELEM_W-1:0]       sum_out
);

  logic              clr;
  logic              accept;
  logic              last_chunk;
  logic              fold_step;
  logic [TAKE_W-1:0] fold_half;
  logic              fold_last;

  ssr_strip_ctrl #(.LANES(LANES), .LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .n_elems    (n_elems),
    .chunk_valid(chunk_valid),
    .busy       (busy),
    .chunk_ready(chunk_ready),
    .take       (chunk_take),
    .clr        (clr),
    .accept     (accept),
    .last_chunk (last_chunk),
    .fold_step  (fold_step),
    .fold_half  (fold_half),
    .fold_last  (fold_last),
    .done       (sum_valid)
  );

  ssr_lane_bank #(.LANES(LANES), .ELEM_W(ELEM_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .add_en   (accept),
    .add_cnt  (chunk_take),
    .add_data (chunk_data),
    .fold_en  (fold_step),
    .fold_half(fold_half),
    .lane0    (sum_out)
  );

endmodule

// File: rtl/ssr_checker.sv
module ssr_checker #(
  parameter int LANES  = 64,
  parameter int ELEM_W = 32,
  localparam int LW     = $clog2(LANES),
  localparam int TAKE_W = LW + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              chunk_ready,
  input logic [TAKE_W-1:0] chunk_take,
  input logic              sum_valid,
  input logic [ELEM_W-1:0] sum_out,
  input logic              clr,
  input logic              accept,
  input logic              last_chunk,
  input logic              fold_step,
  input logic              fold_last
);

  logic [TAKE_W-1:0] fold_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fold_cnt <= '0;
    else if (fold_step) fold_cnt <= fold_cnt + 1'b1;
    else                fold_cnt <= '0;
  end

  // R9
  ready_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_ready |-> busy);

  // R3
  take_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_ready |-> (chunk_take != '0 && chunk_take <= TAKE_W'(LANES)));

  // R3
  later_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !last_chunk) |=> (chunk_take == TAKE_W'(LANES)));

  // R2
  clear_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum_out == '0));

  // R5
  fold_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> (fold_cnt == TAKE_W'(LW)));

  // R6
  valid_after_fold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fold_last |=> sum_valid);

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |=> !sum_valid);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(sum_out));

endmodule

bind strip_sum_reducer ssr_checker #(.LANES(LANES), .ELEM_W(ELEM_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .chunk_ready(chunk_ready),
  .chunk_take (chunk_take),
  .sum_valid  (sum_valid),
  .sum_out    (sum_out),
  .clr        (clr),
  .accept     (accept),
  .last_chunk (last_chunk),
  .fold_step  (fold_step),
  .fold_last  (fold_last)
);

// File: tb/strip_sum_reducer_test.sv
module strip_sum_reducer_test;

  localparam int LANES  = 64;
  localparam int ELEM_W = 32;
  localparam int LEN_W  = 16;
  localparam int TAKE_W = $clog2(LANES) + 1;
  localparam int LOG2   = $clog2(LANES);
  localparam int NVEC   = 8;

  // run table: element count, seed (0 = all 0x8000_0000), stall gap
  localparam int TBL_N    [NVEC] = '{1, 63, 64, 65, 128, 130, 200, 3};
  localparam int TBL_SEED [NVEC] = '{5, 7, 11, 13, 17, 19, 23, 0};
  localparam int TBL_GAP  [NVEC] = '{0, 0, 2, 0, 1, 0, 0, 0};

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    start = 1'b0;
  logic [LEN_W-1:0]        n_elems = '0;
  logic                    chunk_valid = 1'b0;
  logic [LANES*ELEM_W-1:0] chunk_data = '0;
  logic                    busy;
  logic                    chunk_ready;
  logic [TAKE_W-1:0]       chunk_take;
  logic                    sum_valid;
  logic [ELEM_W-1:0]       sum_out;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  strip_sum_reducer #(.LANES(LANES), .ELEM_W(ELEM_W), .LEN_W(LEN_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_elems(n_elems),
    .chunk_valid(chunk_valid), .chunk_data(chunk_data), .busy(busy),
    .chunk_ready(chunk_ready), .chunk_take(chunk_take),
    .sum_valid(sum_valid), .sum_out(sum_out)
  );

  function automatic logic [31:0] gen(input int seed, input int i);
    if (seed == 0) return 32'h8000_0000;
    return ((32'(seed) * 32'h9E37_79B1) ^ (32'(i) * 32'h0100_0193)) + 32'(i);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_garbage();
    for (int j = 0; j < LANES; j++) chunk_data[j*ELEM_W +: ELEM_W] = 32'hDEAD_BEEF;
  endtask

  task automatic run_case(input int n, input int seed, input int gap, input bit poke);
    int left = n;
    int base = 0;
    bit early = 1'b0;
    logic [31:0] expv = '0;
    for (int i = 0; i < n; i++) expv = expv + gen(seed, i);   // R8 wrapped serial sum
    @(negedge clk);
    start = 1'b1;
    n_elems = LEN_W'(n);
    @(negedge clk);
    start = 1'b0;
    if (n == 0) check(chunk_ready == 1'b0, "R7 no chunk requested", 32'(chunk_ready), 0);
    while (left > 0) begin
      int tk = (left % LANES == 0) ? LANES : left % LANES;
      int g = 0;
      while (!chunk_ready && g < 100) begin @(negedge clk); g++; end
      check(int'(chunk_take) == tk, "R3 chunk size", 32'(chunk_take), 32'(tk));
      for (int j = 0; j < LANES; j++)
        chunk_data[j*ELEM_W +: ELEM_W] = (j < tk) ? gen(seed, base + j) : 32'hDEAD_BEEF; // R4
      chunk_valid = 1'b1;
      if (poke) begin start = 1'b1; n_elems = 16'd7; end                              // R2
      @(negedge clk);
      chunk_valid = 1'b0;
      start = 1'b0;
      left -= tk;
      base += tk;
      if (left > 0) repeat (gap) @(negedge clk);                                      // R10
    end
    if (poke) begin fill_garbage(); chunk_valid = 1'b1; end                           // R9
    repeat (LOG2) begin
      if (sum_valid) early = 1'b1;
      @(negedge clk);
    end
    chunk_valid = 1'b0;
    check(sum_valid && !early, "R6 valid timing", {31'd0, sum_valid}, 1);
    check(sum_out == expv, (n == 0) ? "R7 zero sum" : "R5 R8 total", sum_out, expv);
    @(negedge clk);
    check(!sum_valid, "R6 single pulse", {31'd0, sum_valid}, 0);
    check(sum_out == expv, "R6 result held", sum_out, expv);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!busy && !chunk_ready && !sum_valid, "R1 reset flags",
          {29'd0, busy, chunk_ready, sum_valid}, 0);
    check(sum_out == '0, "R1 reset sum", sum_out, 0);

    for (int v = 0; v < NVEC; v++) run_case(TBL_N[v], TBL_SEED[v], TBL_GAP[v], 1'b0);

    // R7 empty run
    run_case(0, 3, 0, 1'b0);
    // R2 R9 start during run and chunks offered while folding
    run_case(100, 29, 1, 1'b1);

    // R9 chunk offered while idle
    held = sum_out;
    fill_garbage();
    chunk_valid = 1'b1;
    repeat (4) @(negedge clk);
    chunk_valid = 1'b0;
    check(sum_out == held && !busy, "R9 idle chunk ignored", sum_out, held);

    // R2 fresh start clears a nonzero bank
    run_case(2, 31, 0, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule